// File: doc/BRIEF.md
# Single-Channel Memory/Peripheral Transfer Engine

This block moves a programmed number of bytes from a source address to a destination address. It does so as a bus master that issues one read or write at a time and waits for an acknowledge or an error on each one. A small register port sets the source, the destination, the byte count and a control word, and it reads them back. The control word starts a run, aborts it through a soft reset, and selects one of two pacing modes. In self-paced mode the engine runs back to back. In peripheral-paced mode it waits for a request line before each transfer unit and raises an acknowledge while it touches the peripheral side.

The peripheral can be the source or the destination. The engine can move plain bytes or 16-bit words. It can also pack, so that two 8-bit peripheral accesses match one 16-bit memory access. The end-of-transfer line is split into an input, an output and an output enable. The engine drives it on the bus cycle that uses up the count. A peripheral may pull it to stop the run early. Four sticky, write-one-to-clear flags record how a run ended: clean finish, failed read, failed write, and an early stop that landed between the two halves of a packed word.

Top module: `dma_channel`

## Requirements
- R1: After reset every register reads zero (address 0 control, 1 source, 2 destination, 3 count, 4 flags), and no bus request, acknowledge or end-of-transfer output is active.
- R2: Control bits are: 0 start, 1 soft reset, 2 peripheral-paced, 3 source increment, 4 destination increment, 5 peripheral is destination, 6 word size, 7 pack. Bit 8 reads back as busy. A run copies count bytes. A unit is 2 bytes in word or pack mode when at least 2 remain, and 1 byte otherwise. The count drops by the unit size after each unit's last write. An enabled address steps by the size of each acknowledged access on its side.
- R3: In self-paced mode the request input has no effect and the acknowledge output stays low.
- R4: In peripheral-paced mode a unit starts only while the request input is high. The acknowledge output is high exactly during bus cycles on the peripheral side.
- R5: The end-of-transfer output and its enable are high only during the write cycle that brings the count to zero.
- R6: An end-of-transfer input seen with an acknowledged access lets the current unit complete, then stops the run and sets flag bit 0 (normal end).
- R7: In pack mode the peripheral side makes byte accesses and the memory side makes word accesses. The first peripheral byte sits in the low half of the word.
- R8: If the end-of-transfer input arrives on the first byte of a packed pair, the second byte and the word access still run. Then flag bits 0 and 3 are both set.
- R9: With an odd count the last unit is a single byte, and a stop on that byte never sets flag bit 3.
- R10: An error response on a read stops the run at once and sets flag bit 1, not bit 0.
- R11: An error response on a write stops the run at once and sets flag bit 2, not bit 0.
- R12: Writing ones to the flags register clears those bits, and zeros leave them unchanged. A soft reset clears all flags and aborts a run.
- R13: After any end the engine stays idle whatever the request input does, until it is started again. Starting with a zero count sets flag bit 0 at once, with no bus cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 3 | Register address |
| reg_wdata_i | input | AW | Register write data |
| reg_rdata_o | output | AW | Register read data (combinational) |
| bus_req_o | output | 1 | Bus cycle request, held until response |
| bus_we_o | output | 1 | 1 for write cycle |
| bus_size_o | output | 1 | 1 for 16-bit access, 0 for byte on bits 7:0 |
| bus_addr_o | output | AW | Byte address |
| bus_wdata_o | output | 16 | Write data |
| bus_rdata_i | input | 16 | Read data, valid with acknowledge |
| bus_ack_i | input | 1 | Cycle completed |
| bus_err_i | input | 1 | Cycle failed |
| dreq_i | input | 1 | Peripheral service request |
| dack_o | output | 1 | Peripheral access acknowledge |
| done_i | input | 1 | End-of-transfer line, incoming |
| done_o | output | 1 | End-of-transfer line, outgoing value |
| done_oe_o | output | 1 | End-of-transfer output enable |

## Verification
The copy function runs with byte, word and both packing directions, with odd and even counts, and in both pacing modes. Odd counts show whether the trailing single byte is handled. The two packing directions show whether byte order and the access count per side are right. Peripheral-paced runs show that acknowledge follows only the peripheral side. Stops and errors injected on chosen bus cycles show the remaining count and separate the four flags. A stop on the first half of a pair is compared with one on an odd trailing byte.

// File: rtl/dma_pkg.sv
package dma_pkg;
  localparam int unsigned RA_CTRL = 0;
  localparam int unsigned RA_SRC  = 1;
  localparam int unsigned RA_DST  = 2;
  localparam int unsigned RA_CNT  = 3;
  localparam int unsigned RA_STAT = 4;

  localparam int unsigned ST_DONE = 0;
  localparam int unsigned ST_RDER = 1;
  localparam int unsigned ST_WRER = 2;
  localparam int unsigned ST_SPLT = 3;
  localparam int unsigned ST_W    = 4;

  // field order matches control bits 7..2
  typedef struct packed {
    logic pack;
    logic word;
    logic to_periph;
    logic dst_inc;
    logic src_inc;
    logic ext;
  } cfg_t;

  typedef enum logic [1:0] {S_IDLE, S_WAIT, S_RD, S_WR} state_e;
endpackage

// File: rtl/dma_regs.sv
module dma_regs
  import dma_pkg::*;
#(
  parameter int unsigned AW = 24,
  parameter int unsigned CW = 16
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            we_i,
  input  logic [2:0]      addr_i,
  input  logic [AW-1:0]   wdata_i,
  output logic [AW-1:0]   rdata_o,
  input  logic            active_i,
  input  logic [AW-1:0]   src_i,
  input  logic [AW-1:0]   dst_i,
  input  logic [CW-1:0]   cnt_i,
  input  logic [ST_W-1:0] ev_i,
  output cfg_t            cfg_o,
  output logic [ST_W-1:0] stat_o,
  output logic            start_o,
  output logic            abort_o,
  output logic            ld_src_o,
  output logic            ld_dst_o,
  output logic            ld_cnt_o
);
  logic ctrl_wr, stat_wr;
  cfg_t cfg_q;
  logic [ST_W-1:0] stat_q;

  assign ctrl_wr  = we_i && (addr_i == 3'(RA_CTRL));
  assign stat_wr  = we_i && (addr_i == 3'(RA_STAT));
  assign abort_o  = ctrl_wr && wdata_i[1];
  assign start_o  = ctrl_wr && wdata_i[0] && !wdata_i[1] && !active_i;
  assign ld_src_o = we_i && (addr_i == 3'(RA_SRC)) && !active_i;
  assign ld_dst_o = we_i && (addr_i == 3'(RA_DST)) && !active_i;
  assign ld_cnt_o = we_i && (addr_i == 3'(RA_CNT)) && !active_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_q  <= '0;
      stat_q <= '0;
    end else begin
      if (ctrl_wr && !active_i) cfg_q <= cfg_t'(wdata_i[7:2]);
      if (abort_o) stat_q <= '0;
      else if (stat_wr) stat_q <= (stat_q & ~wdata_i[ST_W-1:0]) | ev_i;
      else stat_q <= stat_q | ev_i;
    end
  end

  assign cfg_o  = cfg_q;
  assign stat_o = stat_q;

  always_comb begin
    rdata_o = '0;
    unique case (addr_i)
      3'(RA_CTRL): rdata_o = AW'({active_i, cfg_q, 2'b00});
      3'(RA_SRC):  rdata_o = src_i;
      3'(RA_DST):  rdata_o = dst_i;
      3'(RA_CNT):  rdata_o = AW'(cnt_i);
      3'(RA_STAT): rdata_o = AW'(stat_q);
      default:     rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/dma_engine.sv
module dma_engine
  import dma_pkg::*;
#(
  parameter int unsigned AW = 24,
  parameter int unsigned CW = 16
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  cfg_t            cfg_i,
  input  logic            start_i,
  input  logic            abort_i,
  input  logic            ld_src_i,
  input  logic            ld_dst_i,
  input  logic            ld_cnt_i,
  input  logic [AW-1:0]   ld_val_i,
  output logic            bus_req_o,
  output logic            bus_we_o,
  output logic            bus_size_o,
  output logic [AW-1:0]   bus_addr_o,
  output logic [15:0]     bus_wdata_o,
  input  logic [15:0]     bus_rdata_i,
  input  logic            bus_ack_i,
  input  logic            bus_err_i,
  input  logic            dreq_i,
  output logic            dack_o,
  input  logic            done_i,
  output logic            done_o,
  output logic            done_oe_o,
  output logic            active_o,
  output logic [AW-1:0]   src_o,
  output logic [AW-1:0]   dst_o,
  output logic [CW-1:0]   cnt_o,
  output logic [ST_W-1:0] ev_o
);
  state_e state_q;
  logic [AW-1:0] src_q, dst_q;
  logic [CW-1:0] cnt_q, cnt_after;
  logic [15:0] buf_q;
  logic [1:0] ubytes_q, next_ubytes, acc_bytes;
  logic idx_q, stop_q, split_q;
  logic [ST_W-1:0] ev_q;

  logic periph_src, two_p, on_p, acc_last, first_half, fin, ext_stop;

  always_comb begin
    periph_src  = !cfg_i.to_periph;
    two_p       = cfg_i.pack && (ubytes_q == 2'd2);
    on_p        = ((state_q == S_RD) && periph_src) || ((state_q == S_WR) && !periph_src);
    acc_bytes   = (on_p && cfg_i.pack) ? 2'd1 : ubytes_q;
    acc_last    = on_p ? (!two_p || idx_q) : 1'b1;
    first_half  = on_p && two_p && !idx_q;
    fin         = (state_q == S_WR) && acc_last && (cnt_q == CW'(ubytes_q));
    ext_stop    = done_i && !fin;
    next_ubytes = ((cfg_i.word || cfg_i.pack) && (cnt_q > CW'(1))) ? 2'd2 : 2'd1;
    cnt_after   = cnt_q - CW'(ubytes_q);
  end

  assign bus_req_o   = (state_q == S_RD) || (state_q == S_WR);
  assign bus_we_o    = (state_q == S_WR);
  assign bus_size_o  = (acc_bytes == 2'd2);
  assign bus_addr_o  = (state_q == S_WR) ? dst_q : src_q;
  assign bus_wdata_o = bus_size_o ? buf_q : {8'h00, idx_q ? buf_q[15:8] : buf_q[7:0]};
  assign dack_o      = cfg_i.ext && on_p;
  assign done_o      = fin;
  assign done_oe_o   = fin;
  assign active_o    = (state_q != S_IDLE);
  assign src_o       = src_q;
  assign dst_o       = dst_q;
  assign cnt_o       = cnt_q;
  assign ev_o        = ev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= S_IDLE;
      src_q    <= '0;
      dst_q    <= '0;
      cnt_q    <= '0;
      buf_q    <= '0;
      ubytes_q <= 2'd1;
      idx_q    <= 1'b0;
      stop_q   <= 1'b0;
      split_q  <= 1'b0;
      ev_q     <= '0;
    end else begin
      ev_q <= '0;
      if (abort_i) begin
        state_q <= S_IDLE;
      end else begin
        unique case (state_q)
          S_IDLE: begin
            if (ld_src_i) src_q <= ld_val_i;
            if (ld_dst_i) dst_q <= ld_val_i;
            if (ld_cnt_i) cnt_q <= ld_val_i[CW-1:0];
            if (start_i) begin
              stop_q  <= 1'b0;
              split_q <= 1'b0;
              if (cnt_q == '0) ev_q[ST_DONE] <= 1'b1;
              else state_q <= S_WAIT;
            end
          end
          S_WAIT: begin
            if (!cfg_i.ext || dreq_i) begin
              ubytes_q <= next_ubytes;
              idx_q    <= 1'b0;
              state_q  <= S_RD;
            end
          end
          S_RD: begin
            if (bus_err_i) begin
              ev_q[ST_RDER] <= 1'b1;
              state_q       <= S_IDLE;
            end else if (bus_ack_i) begin
              if (bus_size_o) buf_q <= bus_rdata_i;
              else if (idx_q) buf_q[15:8] <= bus_rdata_i[7:0];
              else buf_q[7:0] <= bus_rdata_i[7:0];
              if (cfg_i.src_inc) src_q <= src_q + AW'(acc_bytes);
              if (ext_stop) stop_q <= 1'b1;
              if (first_half && ext_stop) split_q <= 1'b1;
              if (acc_last) begin
                idx_q   <= 1'b0;
                state_q <= S_WR;
              end else begin
                idx_q <= 1'b1;
              end
            end
          end
          S_WR: begin
            if (bus_err_i) begin
              ev_q[ST_WRER] <= 1'b1;
              state_q       <= S_IDLE;
            end else if (bus_ack_i) begin
              if (cfg_i.dst_inc) dst_q <= dst_q + AW'(acc_bytes);
              if (ext_stop) stop_q <= 1'b1;
              if (first_half && ext_stop) split_q <= 1'b1;
              if (acc_last) begin
                cnt_q <= cnt_after;
                if ((cnt_after == '0) || stop_q || ext_stop) begin
                  ev_q[ST_DONE] <= 1'b1;
                  ev_q[ST_SPLT] <= split_q;
                  state_q       <= S_IDLE;
                end else begin
                  state_q <= S_WAIT;
                end
              end else begin
                idx_q <= 1'b1;
              end
            end
          end
          default: state_q <= S_IDLE;
        endcase
      end
    end
  end
endmodule

// File: rtl/dma_channel.sv
module dma_channel
  import dma_pkg::*;
#(
  parameter int unsigned AW = 24,
  parameter int unsigned CW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          reg_we_i,
  input  logic [2:0]    reg_addr_i,
  input  logic [AW-1:0] reg_wdata_i,
  output logic [AW-1:0] reg_rdata_o,
  output logic          bus_req_o,
  output logic          bus_we_o,
  output logic          bus_size_o,
  output logic [AW-1:0] bus_addr_o,
  output logic [15:0]   bus_wdata_o,
  input  logic [15:0]   bus_rdata_i,
  input  logic          bus_ack_i,
  input  logic          bus_err_i,
  input  logic          dreq_i,
  output logic          dack_o,
  input  logic          done_i,
  output logic          done_o,
  output logic          done_oe_o
);
  cfg_t cfg;
  logic active, start, abort, ld_src, ld_dst, ld_cnt;
  logic [AW-1:0] src, dst;
  logic [CW-1:0] cnt;
  logic [ST_W-1:0] ev, stat;

  dma_regs #(.AW(AW), .CW(CW)) u_regs (
    .clk_i, .rst_ni,
    .we_i(reg_we_i), .addr_i(reg_addr_i), .wdata_i(reg_wdata_i), .rdata_o(reg_rdata_o),
    .active_i(active), .src_i(src), .dst_i(dst), .cnt_i(cnt), .ev_i(ev),
    .cfg_o(cfg), .stat_o(stat), .start_o(start), .abort_o(abort),
    .ld_src_o(ld_src), .ld_dst_o(ld_dst), .ld_cnt_o(ld_cnt)
  );

  dma_engine #(.AW(AW), .CW(CW)) u_eng (
    .clk_i, .rst_ni,
    .cfg_i(cfg), .start_i(start), .abort_i(abort),
    .ld_src_i(ld_src), .ld_dst_i(ld_dst), .ld_cnt_i(ld_cnt), .ld_val_i(reg_wdata_i),
    .bus_req_o, .bus_we_o, .bus_size_o, .bus_addr_o, .bus_wdata_o, .bus_rdata_i,
    .bus_ack_i, .bus_err_i, .dreq_i, .dack_o, .done_i, .done_o, .done_oe_o,
    .active_o(active), .src_o(src), .dst_o(dst), .cnt_o(cnt), .ev_o(ev)
  );
endmodule

// File: rtl/dma_channel_chk.sv
module dma_channel_chk #(
  parameter int unsigned AW = 24
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          reg_we_i,
  input logic          bus_req_o,
  input logic          bus_we_o,
  input logic [AW-1:0] bus_addr_o,
  input logic          bus_ack_i,
  input logic          bus_err_i,
  input logic          dack_o,
  input logic          done_o,
  input logic          done_oe_o,
  input logic          ext_i,
  input logic          active_i,
  input logic [3:0]    stat_i
);
  p_req_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_req_o && !bus_ack_i && !bus_err_i && !reg_we_i) |=> (bus_req_o && $stable(bus_addr_o)));

  p_no_dack_self_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dack_o |-> ext_i);

  p_dack_in_cycle_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dack_o |-> bus_req_o);

  p_done_out_write_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (done_oe_o && bus_req_o && bus_we_o));

  p_split_with_done_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(stat_i[3]) |-> stat_i[0]);

  p_rderr_not_done_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(stat_i[1]) |-> !$rose(stat_i[0]));

  p_wrerr_not_done_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(stat_i[2]) |-> !$rose(stat_i[0]));

  p_idle_quiet_r13: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !active_i |-> (!bus_req_o && !dack_o));
endmodule

bind dma_channel dma_channel_chk #(.AW(AW)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .reg_we_i(reg_we_i),
  .bus_req_o(bus_req_o), .bus_we_o(bus_we_o), .bus_addr_o(bus_addr_o),
  .bus_ack_i(bus_ack_i), .bus_err_i(bus_err_i), .dack_o(dack_o),
  .done_o(done_o), .done_oe_o(done_oe_o), .ext_i(cfg.ext),
  .active_i(active), .stat_i(stat)
);

// File: tb/dma_channel_tb_top.sv
module dma_channel_tb_top;
  localparam int AW = 24;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic reg_we_i = 1'b0;
  logic [2:0] reg_addr_i = '0;
  logic [AW-1:0] reg_wdata_i = '0;
  logic [AW-1:0] reg_rdata_o;
  logic bus_req_o, bus_we_o, bus_size_o;
  logic [AW-1:0] bus_addr_o;
  logic [15:0] bus_wdata_o;
  logic [15:0] bus_rdata_i = '0;
  logic bus_ack_i = 1'b0, bus_err_i = 1'b0;
  logic dreq_i = 1'b0, done_i = 1'b0;
  logic dack_o, done_o, done_oe_o;

  always #4 clk_i = ~clk_i;

  dma_channel #(.AW(AW), .CW(16)) dut_i (
    .clk_i, .rst_ni, .reg_we_i, .reg_addr_i, .reg_wdata_i, .reg_rdata_o,
    .bus_req_o, .bus_we_o, .bus_size_o, .bus_addr_o, .bus_wdata_o, .bus_rdata_i,
    .bus_ack_i, .bus_err_i, .dreq_i, .dack_o, .done_i, .done_o, .done_oe_o
  );

  int checks = 0, errors = 0;
  logic [7:0] mem [256];
  int resp_n, dack_n, doneo_n, doneo_idx, err_at = -1, done_at = -1;

  // bus and peripheral responder: one response per request, 2 cycles per access
  always @(negedge clk_i) begin
    if (bus_ack_i || bus_err_i) begin
      bus_ack_i = 1'b0; bus_err_i = 1'b0; done_i = 1'b0;
    end else if (bus_req_o) begin
      if (resp_n == err_at) bus_err_i = 1'b1;
      else begin
        bus_ack_i = 1'b1;
        if (bus_we_o) begin
          mem[bus_addr_o[7:0]] = bus_wdata_o[7:0];
          if (bus_size_o) mem[8'(bus_addr_o[7:0] + 8'd1)] = bus_wdata_o[15:8];
        end else begin
          bus_rdata_i = {bus_size_o ? mem[8'(bus_addr_o[7:0] + 8'd1)] : 8'h00, mem[bus_addr_o[7:0]]};
        end
      end
      if (resp_n == done_at) done_i = 1'b1;
      if (dack_o) dack_n++;
      if (done_o && done_oe_o) begin doneo_n++; doneo_idx = resp_n; end
      resp_n++;
    end
  end

  task automatic chk(input logic ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic reg_wr(input int a, input int d);
    @(negedge clk_i);
    reg_we_i = 1'b1; reg_addr_i = 3'(a); reg_wdata_i = AW'(d);
    @(negedge clk_i);
    reg_we_i = 1'b0;
  endtask

  task automatic reg_rd(input int a, output int d);
    @(negedge clk_i);
    reg_addr_i = 3'(a);
    #1 d = int'(reg_rdata_o);
  endtask

  task automatic wait_idle();
    int v;
    for (int i = 0; i < 3000; i++) begin
      reg_rd(0, v);
      if (v[8] == 1'b0) break;
    end
  endtask

  task automatic init_mem();
    for (int i = 0; i < 256; i++) mem[i] = 8'(i * 7 + 3);
  endtask

  task automatic run(input int ctrl, input int cnt, input int e_at, input int d_at);
    init_mem();
    err_at = e_at; done_at = d_at;
    resp_n = 0; dack_n = 0; doneo_n = 0; doneo_idx = -1;
    reg_wr(4, 'hF);
    reg_wr(1, 'h10);
    reg_wr(2, 'h40);
    reg_wr(3, cnt);
    reg_wr(0, ctrl | 1);
    wait_idle();
  endtask

  task automatic chk_copy(input int n, input string req);
    for (int i = 0; i < n; i++)
      chk(mem['h40 + i] == 8'((16 + i) * 7 + 3), req, int'(mem['h40 + i]), (16 + i) * 7 + 3);
    chk(mem['h40 + n] == 8'((64 + n) * 7 + 3), req, int'(mem['h40 + n]), (64 + n) * 7 + 3);
  endtask

  // {ctrl, count, expected bus cycles}
  localparam logic [23:0] VEC [7] = '{
    {8'h18, 8'd5, 8'd10},  // byte, self-paced
    {8'h58, 8'd5, 8'd6},   // word, odd count
    {8'h58, 8'd6, 8'd6},   // word, even count
    {8'h98, 8'd4, 8'd6},   // pack, peripheral source
    {8'hB8, 8'd5, 8'd8},   // pack, peripheral destination, odd
    {8'h5C, 8'd4, 8'd4},   // word, peripheral-paced
    {8'h9C, 8'd3, 8'd5}    // pack, peripheral-paced, odd
  };

  initial begin
    int v;
    repeat (150000) @(posedge clk_i);
    errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int v, ctrl, cnt, cyc, expd;
    init_mem();
    resp_n = 0; dack_n = 0; doneo_n = 0; doneo_idx = -1;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;

    // R1 reset state
    for (int a = 0; a < 5; a++) begin
      reg_rd(a, v);
      chk(v == 0, "R1", v, 0);
    end
    chk(!bus_req_o && !dack_o && !done_oe_o, "R1", int'({bus_req_o, dack_o, done_oe_o}), 0);

    // vector table: copy runs (R2 R3 R4 R5 R7)
    foreach (VEC[k]) begin
      ctrl = int'(VEC[k][23:16]); cnt = int'(VEC[k][15:8]); cyc = int'(VEC[k][7:0]);
      dreq_i = ctrl[2];
      run(ctrl, cnt, -1, -1);
      chk(resp_n == cyc, "R2 cycles", resp_n, cyc);
      reg_rd(3, v); chk(v == 0, "R2 count", v, 0);
      reg_rd(1, v); chk(v == 'h10 + cnt, "R2 src", v, 'h10 + cnt);
      reg_rd(2, v); chk(v == 'h40 + cnt, "R2 dst", v, 'h40 + cnt);
      reg_rd(4, v); chk(v == 1, "R2 flags", v, 1);
      chk_copy(cnt, "R7 data");
      expd = ctrl[2] ? (ctrl[7] ? cnt : cyc / 2) : 0;
      chk(dack_n == expd, ctrl[2] ? "R4 dack" : "R3 dack", dack_n, expd);
      chk(doneo_n == 1 && doneo_idx == cyc - 1, "R5 done out", doneo_idx, cyc - 1);
    end
    dreq_i = 1'b0;

    // R6 early stop from peripheral
    run('h58, 8, -1, 2);
    chk(resp_n == 4, "R6 cycles", resp_n, 4);
    reg_rd(3, v); chk(v == 4, "R6 count", v, 4);
    reg_rd(4, v); chk(v == 1, "R6 flags", v, 1);
    chk(doneo_n == 0, "R5 no out on stop", doneo_n, 0);

    // R8 stop on first byte of packed pair
    run('h98, 6, -1, 0);
    chk(resp_n == 3, "R8 cycles", resp_n, 3);
    reg_rd(3, v); chk(v == 4, "R8 count", v, 4);
    reg_rd(4, v); chk(v == 'h9, "R8 flags", v, 'h9);
    chk(mem['h40] == 8'(16 * 7 + 3) && mem['h41] == 8'(17 * 7 + 3), "R8 data", int'(mem['h41]), 17 * 7 + 3);

    // R9 stop on trailing odd byte
    run('h98, 3, -1, 3);
    chk(resp_n == 5, "R9 cycles", resp_n, 5);
    reg_rd(4, v); chk(v == 1, "R9 flags", v, 1);

    // R10 read error
    run('h58, 6, 2, -1);
    chk(resp_n == 3, "R10 cycles", resp_n, 3);
    reg_rd(3, v); chk(v == 4, "R10 count", v, 4);
    reg_rd(4, v); chk(v == 2, "R10 flags", v, 2);
    reg_rd(0, v); chk(v[8] == 1'b0, "R10 idle", v[8], 0);

    // R11 write error
    run('h58, 6, 1, -1);
    chk(resp_n == 2, "R11 cycles", resp_n, 2);
    reg_rd(3, v); chk(v == 6, "R11 count", v, 6);
    reg_rd(4, v); chk(v == 4, "R11 flags", v, 4);

    // R12 write-one-to-clear
    reg_wr(4, 0);
    reg_rd(4, v); chk(v == 4, "R12 zero write", v, 4);
    reg_wr(4, 4);
    reg_rd(4, v); chk(v == 0, "R12 one write", v, 0);

    // R4 gating by request, R12 soft reset abort
    run('h58, 6, 1, -1);
    err_at = -1; resp_n = 0;
    reg_wr(3, 4);
    reg_wr(0, 'h5D);
    repeat (10) @(negedge clk_i);
    reg_rd(0, v); chk(v[8] == 1'b1, "R4 waits", v[8], 1);
    chk(resp_n == 0, "R4 no cycles", resp_n, 0);
    reg_wr(0, 2);
    reg_rd(0, v); chk(v[8] == 1'b0, "R12 abort", v[8], 0);
    reg_rd(4, v); chk(v == 0, "R12 reset flags", v, 0);

    // R4 paced run proceeds once request rises
    reg_wr(0, 'h5D);
    repeat (4) @(negedge clk_i);
    dreq_i = 1'b1;
    wait_idle();
    chk(resp_n == 4, "R4 run", resp_n, 4);

    // R13 idle after end
    resp_n = 0;
    repeat (20) @(negedge clk_i);
    chk(resp_n == 0, "R13 idle", resp_n, 0);
    dreq_i = 1'b0;
    run('h18, 0, -1, -1);
    chk(resp_n == 0, "R13 zero count cycles", resp_n, 0);
    reg_rd(4, v); chk(v == 1, "R13 zero count flags", v, 1);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule